// File: doc/BRIEF.md
# Iteration Frame Buffer Controller

This block sits in front of an iterative per-pixel update core that must run several refinement passes over each frame. On the first pass of a frame it takes raw pixel words from the source, stores each one in a single-port RAM and forwards the same word downstream marked as fresh. On every later pass it reads the stored frame back in address order and replays it, marked as a repeat, while the source is held off.

The number of passes per frame comes from a configuration input sampled when the first pixel of a frame is accepted. A value of zero selects the built-in default of ten passes, and a value of one turns off replay altogether. A one-cycle completion pulse accompanies the final output word of each frame. The RAM is never written and read in the same cycle.

Top module: `iter_frame_buffer`

## Requirements
- R1: While reset is held, `in_ready` is 1, and `out_valid` and `frame_done` are 0.
- R2: During the first pass, each pixel accepted on a cycle with `in_valid` and `in_ready` both high appears on `out_data` one cycle later, with `out_valid`=1 and `out_fresh`=1.
- R3: `in_ready` drops in the cycle after the last first-pass pixel is accepted. It stays low for exactly (passes-1)*PIXELS cycles. While it is low, `in_valid` and `in_data` have no effect on any output.
- R4: Each replay pass emits the stored frame on consecutive cycles, pixel 0 first, with `out_valid`=1 and `out_fresh`=0. Every word equals the word captured at that position in the first pass.
- R5: The pass count is taken from `passes_cfg` at the moment the first pixel of a frame is accepted. Changes to `passes_cfg` later in that frame do not change how many passes are emitted.
- R6: With `passes_cfg`=1, no replay takes place and `in_ready` stays high throughout the frame.
- R7: With `passes_cfg`=0, the frame is processed in ten passes.
- R8: `frame_done` is a one-cycle pulse that is high together with the frame's final output word. At that point `in_ready` is already 1. `frame_done` is 0 on every other cycle.
- R9: While `in_ready` is high, a cycle without `in_valid` produces no output word in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Source pixel valid |
| in_data | input | DATA_W | Source pixel word |
| in_ready | output | 1 | Block accepts a pixel this cycle |
| passes_cfg | input | ITER_W | Passes per frame (0 selects DEFAULT_PASSES) |
| out_valid | output | 1 | Output word valid |
| out_data | output | DATA_W | Output pixel word |
| out_fresh | output | 1 | 1 for first-pass words, 0 for replayed words |
| frame_done | output | 1 | Pulse with the frame's last output word |

## Verification
Frames are driven with the pass count set to three, one, zero and four. One frame starts at two passes and has its configuration changed to six after its first pixel. Back-to-back pixels are mixed with idle gaps between pixels. The single-pass frame shows that replay can be switched off, and the zero setting checks the default count. The changed-configuration frame shows whether the count is latched at the start of the frame. The gaps separate forwarding on the handshake from free-running output. During replay the source keeps offering junk words, so any acceptance while held off appears as an unexpected or wrong output word. The length of the hold-off window is counted for each frame.

// File: rtl/iter_frame_buffer.sv
module iter_frame_buffer #(
  parameter int DATA_W         = 16,
  parameter int PIXELS         = 16,
  parameter int ITER_W         = 8,
  parameter int DEFAULT_PASSES = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [DATA_W-1:0] in_data,
  output logic              in_ready,
  input  logic [ITER_W-1:0] passes_cfg,
  output logic              out_valid,
  output logic [DATA_W-1:0] out_data,
  output logic              out_fresh,
  output logic              frame_done
);
  localparam int AW = (PIXELS > 2) ? $clog2(PIXELS) : 1;
  localparam logic [AW-1:0] LAST_ADDR = AW'(PIXELS - 1);
  localparam logic [ITER_W-1:0] DEF_CNT = ITER_W'(DEFAULT_PASSES);

  logic [DATA_W-1:0] mem [PIXELS];
  logic              replay_q;
  logic [AW-1:0]     addr_q;
  logic [ITER_W-1:0] pass_q, total_q;

  wire take    = in_valid && !replay_q;
  wire last_px = (addr_q == LAST_ADDR);
  wire [ITER_W-1:0] cfg_eff   = (passes_cfg == '0) ? DEF_CNT : passes_cfg;
  wire [ITER_W-1:0] total_now = (addr_q == '0) ? cfg_eff : total_q;
  wire more_passes = (total_now > ITER_W'(1));
  wire frame_end = replay_q ? (last_px && pass_q == total_q)
                            : (take && last_px && !more_passes);

  assign in_ready = !replay_q;

  always_ff @(posedge clk)
    if (take) mem[addr_q] <= in_data;

  always_ff @(posedge clk)
    if (take)          out_data <= in_data;
    else if (replay_q) out_data <= mem[addr_q];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      replay_q   <= 1'b0;
      addr_q     <= '0;
      pass_q     <= ITER_W'(1);
      total_q    <= ITER_W'(1);
      out_valid  <= 1'b0;
      out_fresh  <= 1'b0;
      frame_done <= 1'b0;
    end else begin
      out_valid  <= take || replay_q;
      out_fresh  <= take;
      frame_done <= frame_end;
      if (take) begin
        if (addr_q == '0) total_q <= cfg_eff;
        if (last_px) begin
          addr_q <= '0;
          if (more_passes) begin
            replay_q <= 1'b1;
            pass_q   <= ITER_W'(2);
          end
        end else begin
          addr_q <= addr_q + AW'(1);
        end
      end else if (replay_q) begin
        if (last_px) begin
          addr_q <= '0;
          if (pass_q == total_q) replay_q <= 1'b0;
          else                   pass_q   <= pass_q + ITER_W'(1);
        end else begin
          addr_q <= addr_q + AW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/ifb_checker.sv
module ifb_checker #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [DATA_W-1:0] in_data,
  input logic              in_ready,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data,
  input logic              out_fresh,
  input logic              frame_done
);
  assert_fresh_follows_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_fresh) |-> ($past(in_valid && in_ready) && out_data == $past(in_data)));

  assert_holdoff_streams_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |-> out_valid);

  assert_replay_not_fresh_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_ready && $past(!in_ready)) |-> (out_valid && !out_fresh));

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |=> !frame_done);

  assert_done_with_beat_R8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> (out_valid && in_ready));

  assert_idle_no_beat_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(in_ready) && !$past(in_valid)) |-> !out_valid);
endmodule

bind iter_frame_buffer ifb_checker #(.DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
  .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
  .out_fresh(out_fresh), .frame_done(frame_done)
);

// File: tb/sim_iter_frame_buffer.sv
`timescale 1ns/1ps
module sim_iter_frame_buffer;
  localparam int DW = 16, NP = 8, IW = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, in_valid, in_ready, out_valid, out_fresh, frame_done;
  logic [DW-1:0] in_data, out_data;
  logic [IW-1:0] passes_cfg;

  iter_frame_buffer #(.DATA_W(DW), .PIXELS(NP), .ITER_W(IW), .DEFAULT_PASSES(10)) u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .passes_cfg(passes_cfg), .out_valid(out_valid),
    .out_data(out_data), .out_fresh(out_fresh), .frame_done(frame_done));

  typedef struct packed { logic [DW-1:0] d; logic fresh; logic done; } exp_t;
  exp_t sb[$];
  exp_t e;
  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !finished) begin
    if (out_valid) begin
      if (sb.size() == 0) chk(0, "R9", "unexpected output word", int'(out_data), -1);
      else begin
        e = sb.pop_front();
        chk(out_data == e.d, e.fresh ? "R2" : "R4", "out_data", int'(out_data), int'(e.d));
        chk(out_fresh == e.fresh, e.fresh ? "R2" : "R4", "out_fresh", int'(out_fresh), int'(e.fresh));
        chk(frame_done == e.done, "R8", "frame_done on word", int'(frame_done), int'(e.done));
      end
    end else if (frame_done) chk(0, "R8", "frame_done without word", 1, 0);
  end

  task automatic run_frame(int cfg, int cfg_later, int seed, int gap, string req);
    int n;
    int cnt;
    logic [DW-1:0] px[NP];
    n = (cfg == 0) ? 10 : cfg;
    for (int i = 0; i < NP; i++) px[i] = DW'(seed * 97 + i * 311) ^ DW'(i << 9);
    for (int i = 0; i < NP; i++) sb.push_back('{px[i], 1'b1, (n == 1 && i == NP-1)});
    for (int p = 2; p <= n; p++)
      for (int i = 0; i < NP; i++) sb.push_back('{px[i], 1'b0, (p == n && i == NP-1)});
    passes_cfg = IW'(cfg);
    for (int i = 0; i < NP; i++) begin
      repeat (gap) begin @(negedge clk); in_valid = 1'b0; end
      @(negedge clk);
      if (i == 1) passes_cfg = IW'(cfg_later);
      in_valid = 1'b1;
      in_data  = px[i];
      @(posedge clk);
    end
    @(negedge clk);
    cnt = 0;
    while (!in_ready && cnt < 1000) begin
      cnt++;
      in_valid = 1'b1;
      in_data  = DW'(16'hDEAD + cnt);
      @(negedge clk);
    end
    in_valid = 1'b0;
    chk(cnt == (n-1)*NP, req, "ready-low cycles", cnt, (n-1)*NP);
    repeat (3) @(negedge clk);
    chk(sb.size() == 0, req, "words still expected", sb.size(), 0);
  endtask

  initial begin
    rst_n = 1'b0; in_valid = 1'b0; in_data = '0; passes_cfg = 8'd3;
    repeat (3) @(negedge clk);
    chk(in_ready == 1'b1, "R1", "in_ready in reset", int'(in_ready), 1);
    chk(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
    chk(frame_done == 1'b0, "R1", "frame_done in reset", int'(frame_done), 0);
    rst_n = 1'b1;
    run_frame(3, 3, 1, 0, "R3");
    run_frame(1, 1, 2, 2, "R6");
    run_frame(0, 0, 3, 0, "R7");
    run_frame(2, 6, 4, 1, "R5");
    run_frame(4, 4, 5, 0, "R3");
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule